// File: doc/BRIEF.md
# Paired-Digit Multiplexed Display Refresh Controller

This block refreshes a multiplexed LED display whose positions mix 7-segment and 14-segment digits. The digits are handled in pairs. The host stages one segment word for each digit of the next pair in two staging registers, called slot A and slot B. An internal refresh clock is derived from the system clock. Each refresh period begins on a rising edge of that clock. At the start of a period the two staged words move into two display latches. The block then shows the two latches one after the other within that period. The digit-select output follows the same order and lights the matching position.

At the start of each period the block advances the pair index and raises an interrupt request. The host answers by staging the next pair and acknowledging the request. If the host has not acknowledged by the next period start, the display latches keep their old contents. This way, half-written data never reaches the display. At every switch between the two latches, the segments go dark for one system cycle so that one digit does not ghost onto the other.

Top module: `disp_refresh_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `seg_out` is all zero, `pair_idx` is 0, `irq` is 0 and `dig_sel` has only bit 1 set.
- R2: A refresh period lasts 2*HALF_CYC system cycles. Slot A shows first, for HALF_CYC cycles, and slot B follows for HALF_CYC cycles. While slot A shows, `dig_sel` has only bit 2*`pair_idx` set. While slot B shows, it has only bit 2*`pair_idx`+1 set. Exactly one bit of `dig_sel` is set at all times.
- R3: Outside the blank cycle, `seg_out` equals the slot A display latch during the A half and the slot B display latch during the B half.
- R4: `seg_out` is all zero during the first system cycle of every half period.
- R5: `irq` becomes 1 at every period start and stays 1 until the host acknowledges it.
- R6: When `irq_ack` is high in a cycle that is not a period start, `irq` is 0 in the next cycle.
- R7: At a period start, both display latches take the staged words only if no request is left unacknowledged. An acknowledge in that same cycle counts. Otherwise both latches keep their contents.
- R8: At each period start `pair_idx` advances by one and wraps from NUM_PAIRS-1 to 0. The first period start after reset is the exception: there `pair_idx` stays 0.
- R9: A host write with `wr_en` high stores `wr_data` into the staging register of slot A (`wr_sel`=0) or slot B (`wr_sel`=1). The write does not change `seg_out` in the period in progress.
- R10: The first period start after reset raises `irq`, with `pair_idx` still 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host staging write strobe |
| wr_sel | input | 1 | Staging register select: 0 for slot A, 1 for slot B |
| wr_data | input | SEG_W | Segment word to stage |
| irq_ack | input | 1 | Acknowledge of the refresh request |
| irq | output | 1 | Refresh request to the host |
| pair_idx | output | IDX_W | Index of the digit pair on display |
| seg_out | output | SEG_W | Segment drive, active high |
| dig_sel | output | 2*NUM_PAIRS | One-hot digit select |

## Verification
The assertions assume that reset is held for at least one clock. They also assume that `irq_ack` is a single-cycle pulse given only while `irq` is high. The bench meets both assumptions. It synchronises to the half-period boundaries that `dig_sel` makes visible. It then does all staging writes and the acknowledge inside the A half, so that no acknowledge coincides with a period start. The bench drives inputs on falling edges, which keeps every strobe exactly one cycle wide.

// File: rtl/disp_refresh_pkg.sv
package disp_refresh_pkg;

  // Next pair index, wrapping after n-1.
  function automatic int unsigned next_pair(int unsigned idx, int unsigned n);
    if (idx + 1 >= n) return 0;
    return idx + 1;
  endfunction

  // Digit position lit for a pair index and half (is_b = 0 for slot A).
  function automatic int unsigned digit_pos(int unsigned idx, bit is_b);
    return 2 * idx + (is_b ? 1 : 0);
  endfunction

endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int HALF_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  output logic phase_a,
  output logic period_start,
  output logic half_first
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic             half_end;

  assign half_end     = (cnt == LAST);
  assign period_start = half_end && !phase_a;
  assign half_first   = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      phase_a <= 1'b0;
    end else if (half_end) begin
      cnt     <= '0;
      phase_a <= ~phase_a;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R2
  period_phase_chk: assert property (@(posedge clk) disable iff (rst)
    period_start |=> phase_a);

endmodule

// File: rtl/pair_seq.sv
module pair_seq
  import disp_refresh_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             period_start,
  input  logic             irq_ack,
  output logic             irq,
  output logic [IDX_W-1:0] pair_idx,
  output logic             load_en
);
  logic started;
  logic still_pending;

  assign still_pending = irq && !irq_ack;
  assign load_en       = period_start && !still_pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq      <= 1'b0;
      pair_idx <= '0;
      started  <= 1'b0;
    end else if (period_start) begin
      irq     <= 1'b1;
      started <= 1'b1;
      if (started)
        pair_idx <= IDX_W'(next_pair(32'(pair_idx), NUM_PAIRS));
    end else if (irq_ack) begin
      irq <= 1'b0;
    end
  end

  // R5
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_ack) |=> irq);

  // R6
  irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !period_start) |=> !irq);

  // R8
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!period_start) |=> $stable(pair_idx));

  // R8
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(pair_idx) < NUM_PAIRS);

endmodule

// File: rtl/seg_bank.sv
module seg_bank #(
  parameter int SEG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [SEG_W-1:0] wr_data,
  input  logic             load_en,
  input  logic             phase_a,
  input  logic             blank,
  output logic [SEG_W-1:0] seg_out
);
  logic [SEG_W-1:0] stage [2];
  logic [SEG_W-1:0] shown [2];

  for (genvar s = 0; s < 2; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        stage[s] <= '0;
        shown[s] <= '0;
      end else begin
        if (wr_en && (wr_sel == 1'(s)))
          stage[s] <= wr_data;
        if (load_en)
          shown[s] <= stage[s];
      end
    end

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      !load_en |=> $stable(shown[s]));
  end

  assign seg_out = blank ? '0 : (phase_a ? shown[0] : shown[1]);

endmodule

// File: rtl/disp_refresh_ctrl.sv
module disp_refresh_ctrl
  import disp_refresh_pkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int NUM_PAIRS = 4,
  parameter int HALF_CYC  = 8,
  parameter int IDX_W     = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   wr_sel,
  input  logic [SEG_W-1:0]       wr_data,
  input  logic                   irq_ack,
  output logic                   irq,
  output logic [IDX_W-1:0]       pair_idx,
  output logic [SEG_W-1:0]       seg_out,
  output logic [2*NUM_PAIRS-1:0] dig_sel
);
  localparam int SEL_W = 2 * NUM_PAIRS;
  localparam int POS_W = $clog2(SEL_W);

  logic             phase_a;
  logic             period_start;
  logic             half_first;
  logic             load_en;
  logic [POS_W-1:0] pos;

  refresh_timer #(.HALF_CYC(HALF_CYC)) i_timer (
    .clk(clk), .rst(rst), .phase_a(phase_a),
    .period_start(period_start), .half_first(half_first)
  );

  pair_seq #(.NUM_PAIRS(NUM_PAIRS), .IDX_W(IDX_W)) i_seq (
    .clk(clk), .rst(rst), .period_start(period_start), .irq_ack(irq_ack),
    .irq(irq), .pair_idx(pair_idx), .load_en(load_en)
  );

  seg_bank #(.SEG_W(SEG_W)) i_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .load_en(load_en), .phase_a(phase_a), .blank(half_first),
    .seg_out(seg_out)
  );

  assign pos     = POS_W'(digit_pos(32'(pair_idx), !phase_a));
  assign dig_sel = SEL_W'(1) << pos;

  // R4
  blank_switch_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(phase_a) |-> (seg_out == '0));

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(dig_sel) == 1);

endmodule

// File: tb/test_disp_refresh_ctrl.sv
`timescale 1ns/1ps
module test_disp_refresh_ctrl;
  localparam int SEG_W = 16;
  localparam int NP    = 4;
  localparam int HALF  = 8;
  localparam int IW    = 2;
  localparam int NV    = 8;

  // {ack, slot A word, slot B word}
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 16'h3FFF, 16'h0001},
    {1'b1, 16'h2A55, 16'h15AA},
    {1'b0, 16'h1234, 16'h4321},
    {1'b1, 16'h0F0F, 16'hF0F0},
    {1'b0, 16'hFFFF, 16'h0000},
    {1'b0, 16'hAAAA, 16'h5555},
    {1'b1, 16'h8001, 16'h7FFE},
    {1'b1, 16'h0000, 16'hFFFF}
  };

  logic clk = 0, rst = 1, wr_en = 0, wr_sel = 0, irq_ack = 0;
  logic [SEG_W-1:0] wr_data = '0;
  logic irq;
  logic [IW-1:0] pair_idx;
  logic [SEG_W-1:0] seg_out;
  logic [2*NP-1:0] dig_sel;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  disp_refresh_ctrl #(.SEG_W(SEG_W), .NUM_PAIRS(NP), .HALF_CYC(HALF)) i_disp_refresh_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .irq_ack(irq_ack), .irq(irq), .pair_idx(pair_idx), .seg_out(seg_out),
    .dig_sel(dig_sel)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit in_a_half(logic [2*NP-1:0] d);
    for (int k = 0; k < NP; k++) if (d[2*k]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic wait_half(bit want_a);
    bit prev, cur;
    prev = in_a_half(dig_sel);
    forever begin
      @(negedge clk);
      cur = in_a_half(dig_sel);
      if (cur == want_a && prev != want_a) break;
      prev = cur;
    end
  endtask

  task automatic host_write(bit sel, logic [SEG_W-1:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic host_ack();
    irq_ack = 1;
    @(negedge clk);
    irq_ack = 0;
  endtask

  initial begin
    int idx;
    logic [SEG_W-1:0] la, lb, sa, sb;
    bit pend, first, acked;
    repeat (3) @(negedge clk);
    chk("R1 seg during reset", 32'(seg_out), 0);
    rst = 0;
    @(negedge clk);
    chk("R1 seg", 32'(seg_out), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 idx", 32'(pair_idx), 0);
    chk("R1 dig_sel", 32'(dig_sel), 32'h2);

    idx = 0; la = 0; lb = 0; sa = 0; sb = 0; pend = 0; first = 1;
    for (int i = 0; i <= NV; i++) begin
      wait_half(1'b1);
      if (!first) idx = (idx + 1) % NP;
      if (!pend) begin la = sa; lb = sb; end
      pend = 1;
      if (first) chk("R10 first irq", 32'(irq), 1);
      first = 0;
      chk("R4 blank at A start", 32'(seg_out), 0);
      chk("R5 irq at period start", 32'(irq), 1);
      chk("R8 pair index", 32'(pair_idx), 32'(idx));
      chk("R2 A select", 32'(dig_sel), 32'(1) << (2 * idx));
      @(negedge clk);
      chk("R3 slot A shown", 32'(seg_out), 32'(la));
      acked = 0;
      if (i < NV) begin
        host_write(1'b0, VEC[i][31:16]); sa = VEC[i][31:16];
        host_write(1'b1, VEC[i][15:0]);  sb = VEC[i][15:0];
        if (VEC[i][32]) begin
          host_ack();
          acked = 1; pend = 0;
          chk("R6 irq cleared", 32'(irq), 0);
        end
        chk("R9 write leaves display", 32'(seg_out), 32'(la));
      end
      wait_half(1'b0);
      chk("R4 blank at B start", 32'(seg_out), 0);
      chk("R2 B select", 32'(dig_sel), 32'(1) << (2 * idx + 1));
      chk("R5 irq held", 32'(irq), acked ? 0 : 1);
      @(negedge clk);
      chk("R3 R7 slot B shown", 32'(seg_out), 32'(lb));
    end

    rst = 1;
    @(negedge clk);
    chk("R1 seg after re-reset", 32'(seg_out), 0);
    chk("R1 irq after re-reset", 32'(irq), 0);
    chk("R1 idx after re-reset", 32'(pair_idx), 0);
    chk("R1 dig_sel after re-reset", 32'(dig_sel), 32'h2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule